// File: doc/BRIEF.md
# Byte-Lane Steering Unit for a 16-bit Host Bus

This unit sits between a 16-bit host data bus and byte-wide devices. Memory is split into two byte-wide banks: the even bank holds even byte addresses and is wired to the low data lane (bits 7..0). The odd bank holds odd byte addresses and is wired to the high lane (bits 15..8). The unit decodes the active-low bank-high-enable and address bit 0 into bank selects and bank write strobes. It hands each bank a word address, and on reads it drives zero on any lane whose bank was not selected.

An 8-bit peripheral wired only to the low lane can still serve odd port addresses. For odd-byte I/O cycles a byte copier moves host bits 15..8 down to the peripheral on writes. On reads it moves the peripheral byte up to host bits 15..8. Even-byte and word I/O cycles pass the low lane straight through. Upper address decoding is handled elsewhere.

The unit registers the host address, enables, write data and strobes on each clock edge. A small cycle tracker then classifies the registered cycle into one of five states:
- `ST_IDLE`: no strobe, or both strobes at once.
- `ST_MEM_RD`: memory read.
- `ST_MEM_WR`: memory write.
- `ST_IO_RD`: I/O read.
- `ST_IO_WR`: I/O write.

The tracker has no memory of its own history. Every edge takes the transition named by the current strobes, from any state:
- Read only: to the read state of the space chosen by `host_io`.
- Write only: to the matching write state.
- Neither strobe, or both strobes: back to `ST_IDLE`.

All outputs follow the state one cycle after the inputs are presented.

Top module: `lane_steer_top`

## Requirements
- R1: In a memory cycle with `host_bhe_n`=0 and address bit 0 = 0 (word access), both `even_sel` and `odd_sel` are 1.
- R2: In a memory cycle with `host_bhe_n`=0 and address bit 0 = 1 (odd byte), only `odd_sel` is 1.
- R3: In a memory cycle with `host_bhe_n`=1 and address bit 0 = 0 (even byte), only `even_sel` is 1.
- R4: With `host_bhe_n`=1 and address bit 0 = 1, neither bank is selected and no bank write strobe rises.
- R5: `bank_addr` equals host address bits 19..1 of the previous cycle.
- R6: `even_wr`/`odd_wr` are 1 only in a memory write (`host_wr_n`=0, `host_io`=0), each gated by its own bank select.
- R7: On a memory read the high result lane carries `odd_rdata` when the odd bank is selected and zero otherwise, and the low lane carries `even_rdata` when the even bank is selected and zero otherwise.
- R8: On an I/O write (`host_io`=1) to an odd byte, `per_wdata` equals host write bits 15..8 and `per_wr` is 1.
- R9: On an I/O read of an odd byte, `host_rdata` is `{per_rdata, 8'h00}` and `per_rd` is 1.
- R10: On an even-byte or word I/O cycle, a write puts host bits 7..0 on `per_wdata`, and a read returns `{8'h00, per_rdata}`.
- R11: An I/O cycle with `host_bhe_n`=1 and address bit 0 = 1 raises neither `per_rd` nor `per_wr`, returns zero, and leaves `per_wdata` zero.
- R12: With read and write strobes active together, the cycle is ignored: no select, strobe or read data. Also, `per_rd`, `per_wr` and any bank select are never active together.
- R13: During reset and in `ST_IDLE` all selects, strobes, `per_wdata` and `host_rdata` are zero, and outputs change only on the clock edge after the inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| host_addr | input | ADDR_W | Host byte address |
| host_bhe_n | input | 1 | Bank-high-enable, active low |
| host_rd_n | input | 1 | Read strobe, active low |
| host_wr_n | input | 1 | Write strobe, active low |
| host_io | input | 1 | 1 = I/O cycle, 0 = memory cycle |
| host_wdata | input | DATA_W | Host write data, both lanes |
| host_rdata | output | DATA_W | Steered read data to host |
| bank_addr | output | ADDR_W-1 | Word address shared by both banks |
| even_sel | output | 1 | Even (low-lane) bank select |
| odd_sel | output | 1 | Odd (high-lane) bank select |
| even_wr | output | 1 | Even bank write strobe |
| odd_wr | output | 1 | Odd bank write strobe |
| mem_wdata | output | DATA_W | Write data to the banks, lanes unswapped |
| even_rdata | input | LANE_W | Even bank read byte |
| odd_rdata | input | LANE_W | Odd bank read byte |
| per_rd | output | 1 | Peripheral read strobe |
| per_wr | output | 1 | Peripheral write strobe |
| per_wdata | output | LANE_W | Peripheral write byte |
| per_rdata | input | LANE_W | Peripheral read byte |

## Verification
The hardest case to reach is a cycle where the memory read lanes and the peripheral byte carry distinct nonzero values. A wrong lane or a missing copy would otherwise still look like a plausible result. The stimulus keeps the bank bytes and the peripheral byte at three different constants across every vector, so each steering path is distinguishable. It walks all four enable combinations in each of the four cycle states, and adds the conflicting-strobe case and the latency case.

// File: rtl/lane_steer_pkg.sv
package lane_steer_pkg;

    // {bhe_n, a0} is the encoding; order is fixed by the bus
    typedef enum logic [1:0] {
        ACC_WORD = 2'b00,
        ACC_ODD  = 2'b01,
        ACC_EVEN = 2'b10,
        ACC_NONE = 2'b11
    } acc_e;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_MEM_RD = 3'd1,
        ST_MEM_WR = 3'd2,
        ST_IO_RD  = 3'd3,
        ST_IO_WR  = 3'd4
    } cyc_e;

endpackage

// File: rtl/lane_decode.sv
module lane_decode
    import lane_steer_pkg::*;
(
    input  logic bhe_n,
    input  logic a0,
    output acc_e kind,
    output logic lo_en,
    output logic hi_en
);

    always_comb begin
        kind  = acc_e'({bhe_n, a0});
        lo_en = 1'b0;
        hi_en = 1'b0;
        unique case (kind)
            ACC_WORD: begin lo_en = 1'b1; hi_en = 1'b1; end
            ACC_ODD:  hi_en = 1'b1;
            ACC_EVEN: lo_en = 1'b1;
            ACC_NONE: ;
        endcase
    end

endmodule

// File: rtl/cycle_fsm.sv
module cycle_fsm
    import lane_steer_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic rd_n,
    input  logic wr_n,
    input  logic io,
    output cyc_e state,
    output logic mem_rd,
    output logic mem_wr,
    output logic io_rd,
    output logic io_wr
);

    cyc_e nxt;

    always_comb begin
        unique case ({rd_n, wr_n})
            2'b01:   nxt = io ? ST_IO_RD : ST_MEM_RD;
            2'b10:   nxt = io ? ST_IO_WR : ST_MEM_WR;
            default: nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        mem_rd = 1'b0;
        mem_wr = 1'b0;
        io_rd  = 1'b0;
        io_wr  = 1'b0;
        unique case (state)
            ST_IDLE:   ;
            ST_MEM_RD: mem_rd = 1'b1;
            ST_MEM_WR: mem_wr = 1'b1;
            ST_IO_RD:  io_rd  = 1'b1;
            ST_IO_WR:  io_wr  = 1'b1;
            default:   ;
        endcase
    end

endmodule

// File: rtl/byte_copier.sv
module byte_copier
    import lane_steer_pkg::*;
#(
    parameter int LANE_W = 8,
    localparam int DATA_W = 2 * LANE_W
) (
    input  logic              mem_rd,
    input  logic              io_rd,
    input  logic              io_wr,
    input  acc_e              kind,
    input  logic              lo_en,
    input  logic              hi_en,
    input  logic [DATA_W-1:0] wdata,
    input  logic [LANE_W-1:0] lo_rdata,
    input  logic [LANE_W-1:0] hi_rdata,
    input  logic [LANE_W-1:0] per_rdata,
    output logic [LANE_W-1:0] per_wdata,
    output logic [DATA_W-1:0] host_rdata
);

    localparam int NLANE = 2;

    logic [LANE_W-1:0] mem_lane [NLANE];
    logic              lane_en  [NLANE];
    logic [LANE_W-1:0] rd_lane  [NLANE];
    logic              io_live;
    logic              io_odd;

    assign mem_lane[0] = lo_rdata;
    assign mem_lane[1] = hi_rdata;
    assign lane_en[0]  = lo_en;
    assign lane_en[1]  = hi_en;
    assign io_live     = (kind != ACC_NONE);
    assign io_odd      = (kind == ACC_ODD);

    for (genvar g = 0; g < NLANE; g++) begin : g_lane
        // lane 1 takes the peripheral byte only for odd I/O; lane 0 otherwise
        localparam bit HIGH = (g == 1);
        always_comb begin
            rd_lane[g] = '0;
            if (mem_rd && lane_en[g])
                rd_lane[g] = mem_lane[g];
            else if (io_rd && io_live && (io_odd == HIGH))
                rd_lane[g] = per_rdata;
        end
        assign host_rdata[g*LANE_W +: LANE_W] = rd_lane[g];
    end

    always_comb begin
        per_wdata = '0;
        if (io_wr && io_live)
            per_wdata = io_odd ? wdata[DATA_W-1:LANE_W] : wdata[LANE_W-1:0];
    end

endmodule

// File: rtl/lane_steer_top.sv
module lane_steer_top
    import lane_steer_pkg::*;
#(
    parameter int ADDR_W = 20,
    parameter int DATA_W = 16,
    parameter int LANE_W = DATA_W / 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic              host_bhe_n,
    input  logic              host_rd_n,
    input  logic              host_wr_n,
    input  logic              host_io,
    input  logic [DATA_W-1:0] host_wdata,
    output logic [DATA_W-1:0] host_rdata,
    output logic [ADDR_W-2:0] bank_addr,
    output logic              even_sel,
    output logic              odd_sel,
    output logic              even_wr,
    output logic              odd_wr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [LANE_W-1:0] even_rdata,
    input  logic [LANE_W-1:0] odd_rdata,
    output logic              per_rd,
    output logic              per_wr,
    output logic [LANE_W-1:0] per_wdata,
    input  logic [LANE_W-1:0] per_rdata
);

    logic [ADDR_W-1:0] addr_q;
    logic              bhe_n_q;
    logic [DATA_W-1:0] wdata_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q  <= '0;
            bhe_n_q <= 1'b1;
            wdata_q <= '0;
        end else begin
            addr_q  <= host_addr;
            bhe_n_q <= host_bhe_n;
            wdata_q <= host_wdata;
        end
    end

    cyc_e state;
    logic mem_rd, mem_wr, io_rd, io_wr;

    cycle_fsm u_fsm (
        .clk    (clk),
        .rst_n  (rst_n),
        .rd_n   (host_rd_n),
        .wr_n   (host_wr_n),
        .io     (host_io),
        .state  (state),
        .mem_rd (mem_rd),
        .mem_wr (mem_wr),
        .io_rd  (io_rd),
        .io_wr  (io_wr)
    );

    acc_e kind;
    logic lo_en, hi_en;

    lane_decode u_dec (
        .bhe_n (bhe_n_q),
        .a0    (addr_q[0]),
        .kind  (kind),
        .lo_en (lo_en),
        .hi_en (hi_en)
    );

    byte_copier #(.LANE_W(LANE_W)) u_copy (
        .mem_rd     (mem_rd),
        .io_rd      (io_rd),
        .io_wr      (io_wr),
        .kind       (kind),
        .lo_en      (lo_en),
        .hi_en      (hi_en),
        .wdata      (wdata_q),
        .lo_rdata   (even_rdata),
        .hi_rdata   (odd_rdata),
        .per_rdata  (per_rdata),
        .per_wdata  (per_wdata),
        .host_rdata (host_rdata)
    );

    logic mem_cyc;
    assign mem_cyc   = mem_rd | mem_wr;
    assign even_sel  = mem_cyc & lo_en;
    assign odd_sel   = mem_cyc & hi_en;
    assign even_wr   = mem_wr & lo_en;
    assign odd_wr    = mem_wr & hi_en;
    assign bank_addr = addr_q[ADDR_W-1:1];
    assign mem_wdata = wdata_q;
    assign per_rd    = io_rd & (kind != ACC_NONE);
    assign per_wr    = io_wr & (kind != ACC_NONE);

endmodule

// File: rtl/lane_steer_chk.sv
module lane_steer_chk #(
    parameter int ADDR_W = 20,
    parameter int DATA_W = 16,
    parameter int LANE_W = DATA_W / 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] host_addr,
    input logic              host_bhe_n,
    input logic              host_rd_n,
    input logic              host_wr_n,
    input logic              host_io,
    input logic [DATA_W-1:0] host_wdata,
    input logic [DATA_W-1:0] host_rdata,
    input logic [ADDR_W-2:0] bank_addr,
    input logic              even_sel,
    input logic              odd_sel,
    input logic              even_wr,
    input logic              odd_wr,
    input logic              per_rd,
    input logic              per_wr,
    input logic [LANE_W-1:0] per_wdata,
    input logic [LANE_W-1:0] per_rdata
);

    logic armed;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) armed <= 1'b0;
        else        armed <= 1'b1;
    end

    // R5
    bank_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        armed |-> bank_addr == $past(host_addr[ADDR_W-1:1]));

    // R1
    word_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        armed && $past(!host_rd_n && host_wr_n && !host_io && !host_bhe_n && !host_addr[0])
        |-> even_sel && odd_sel);

    // R4
    none_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        armed && $past(host_bhe_n && host_addr[0])
        |-> !even_sel && !odd_sel && !per_rd && !per_wr);

    // R6
    even_wr_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        armed && even_wr |-> even_sel && $past(!host_wr_n && host_rd_n && !host_io));

    // R6
    odd_wr_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        armed && odd_wr |-> odd_sel && $past(!host_wr_n && host_rd_n && !host_io));

    // R8
    odd_copy_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        armed && $past(!host_wr_n && host_rd_n && host_io && !host_bhe_n && host_addr[0])
        |-> per_wr && per_wdata == $past(host_wdata[DATA_W-1:LANE_W]));

    // R9
    odd_copy_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        armed && $past(!host_rd_n && host_wr_n && host_io && !host_bhe_n && host_addr[0])
        |-> per_rd && host_rdata == {per_rdata, {LANE_W{1'b0}}});

    // R12
    conflict_chk: assert property (@(posedge clk) disable iff (!rst_n)
        armed && $past(!host_rd_n && !host_wr_n)
        |-> !even_sel && !odd_sel && !per_rd && !per_wr && host_rdata == '0);

    // R12
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({per_rd, per_wr, even_sel | odd_sel}));

endmodule

bind lane_steer_top lane_steer_chk #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LANE_W(LANE_W)
) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .host_addr  (host_addr),
    .host_bhe_n (host_bhe_n),
    .host_rd_n  (host_rd_n),
    .host_wr_n  (host_wr_n),
    .host_io    (host_io),
    .host_wdata (host_wdata),
    .host_rdata (host_rdata),
    .bank_addr  (bank_addr),
    .even_sel   (even_sel),
    .odd_sel    (odd_sel),
    .even_wr    (even_wr),
    .odd_wr     (odd_wr),
    .per_rd     (per_rd),
    .per_wr     (per_wr),
    .per_wdata  (per_wdata),
    .per_rdata  (per_rdata)
);

// File: tb/lane_steer_top_tb_top.sv
module lane_steer_top_tb_top;

    localparam int ADDR_W = 20;
    localparam int DATA_W = 16;
    localparam int LANE_W = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [ADDR_W-1:0] host_addr = '0;
    logic              host_bhe_n = 1'b1;
    logic              host_rd_n = 1'b1;
    logic              host_wr_n = 1'b1;
    logic              host_io = 1'b0;
    logic [DATA_W-1:0] host_wdata = '0;
    logic [DATA_W-1:0] host_rdata;
    logic [ADDR_W-2:0] bank_addr;
    logic              even_sel, odd_sel, even_wr, odd_wr;
    logic [DATA_W-1:0] mem_wdata;
    logic [LANE_W-1:0] even_rdata = 8'hA5;
    logic [LANE_W-1:0] odd_rdata = 8'h3C;
    logic              per_rd, per_wr;
    logic [LANE_W-1:0] per_wdata;
    logic [LANE_W-1:0] per_rdata = 8'h77;

    always #2 clk = ~clk;

    lane_steer_top dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_addr  (host_addr),
        .host_bhe_n (host_bhe_n),
        .host_rd_n  (host_rd_n),
        .host_wr_n  (host_wr_n),
        .host_io    (host_io),
        .host_wdata (host_wdata),
        .host_rdata (host_rdata),
        .bank_addr  (bank_addr),
        .even_sel   (even_sel),
        .odd_sel    (odd_sel),
        .even_wr    (even_wr),
        .odd_wr     (odd_wr),
        .mem_wdata  (mem_wdata),
        .even_rdata (even_rdata),
        .odd_rdata  (odd_rdata),
        .per_rd     (per_rd),
        .per_wr     (per_wr),
        .per_wdata  (per_wdata),
        .per_rdata  (per_rdata)
    );

    typedef struct packed {
        logic        io;
        logic        rd;
        logic        wr;
        logic        bhe_n;
        logic [19:0] addr;
        logic [15:0] wd;
        logic        x_es;
        logic        x_os;
        logic        x_ew;
        logic        x_ow;
        logic        x_pr;
        logic        x_pw;
        logic [7:0]  x_pwd;
        logic [15:0] x_hrd;
    } vec_t;

    localparam int NV = 18;
    localparam vec_t VECS [NV] = '{
        // io rd wr bhe   addr       wd        es os ew ow pr pw pwd    hrd
        '{1'b0,1'b1,1'b0,1'b0,20'h12340,16'h0000,1'b1,1'b1,1'b0,1'b0,1'b0,1'b0,8'h00,16'h3CA5}, // R1 R7
        '{1'b0,1'b1,1'b0,1'b0,20'h12341,16'h0000,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,8'h00,16'h3C00}, // R2 R7
        '{1'b0,1'b1,1'b0,1'b1,20'h12340,16'h0000,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,8'h00,16'h00A5}, // R3 R7
        '{1'b0,1'b1,1'b0,1'b1,20'h12341,16'h0000,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,8'h00,16'h0000}, // R4
        '{1'b0,1'b0,1'b1,1'b0,20'h12340,16'hBEEF,1'b1,1'b1,1'b1,1'b1,1'b0,1'b0,8'h00,16'h0000}, // R1 R6
        '{1'b0,1'b0,1'b1,1'b0,20'h12341,16'hBEEF,1'b0,1'b1,1'b0,1'b1,1'b0,1'b0,8'h00,16'h0000}, // R2 R6
        '{1'b0,1'b0,1'b1,1'b1,20'h12340,16'hBEEF,1'b1,1'b0,1'b1,1'b0,1'b0,1'b0,8'h00,16'h0000}, // R3 R6
        '{1'b0,1'b0,1'b1,1'b1,20'h12341,16'hBEEF,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,8'h00,16'h0000}, // R4 R6
        '{1'b1,1'b0,1'b1,1'b0,20'h12341,16'h5A96,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,8'h5A,16'h0000}, // R8
        '{1'b1,1'b0,1'b1,1'b1,20'h12340,16'h5A96,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,8'h96,16'h0000}, // R10
        '{1'b1,1'b0,1'b1,1'b0,20'h12340,16'h5A96,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,8'h96,16'h0000}, // R10
        '{1'b1,1'b1,1'b0,1'b0,20'h12341,16'h0000,1'b0,1'b0,1'b0,1'b0,1'b1,1'b0,8'h00,16'h7700}, // R9
        '{1'b1,1'b1,1'b0,1'b1,20'h12340,16'h0000,1'b0,1'b0,1'b0,1'b0,1'b1,1'b0,8'h00,16'h0077}, // R10
        '{1'b1,1'b1,1'b0,1'b0,20'h12340,16'h0000,1'b0,1'b0,1'b0,1'b0,1'b1,1'b0,8'h00,16'h0077}, // R10
        '{1'b1,1'b1,1'b0,1'b1,20'h12341,16'h0000,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,8'h00,16'h0000}, // R11
        '{1'b1,1'b0,1'b1,1'b1,20'h12341,16'h5A96,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,8'h00,16'h0000}, // R11
        '{1'b0,1'b1,1'b1,1'b0,20'h12340,16'hBEEF,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,8'h00,16'h0000}, // R12
        '{1'b0,1'b0,1'b0,1'b0,20'h12340,16'h0000,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,8'h00,16'h0000}  // R13
    };

    int n_chk = 0;
    int n_bad = 0;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic check_all(input string tag, input vec_t v);
        check({tag, " even_sel"},   32'(even_sel),   32'(v.x_es));
        check({tag, " odd_sel"},    32'(odd_sel),    32'(v.x_os));
        check({tag, " even_wr"},    32'(even_wr),    32'(v.x_ew));
        check({tag, " odd_wr"},     32'(odd_wr),     32'(v.x_ow));
        check({tag, " per_rd"},     32'(per_rd),     32'(v.x_pr));
        check({tag, " per_wr"},     32'(per_wr),     32'(v.x_pw));
        check({tag, " per_wdata"},  32'(per_wdata),  32'(v.x_pwd));
        check({tag, " host_rdata"}, 32'(host_rdata), 32'(v.x_hrd));
    endtask

    task automatic apply(input vec_t v);
        host_io    = v.io;
        host_rd_n  = ~v.rd;
        host_wr_n  = ~v.wr;
        host_bhe_n = v.bhe_n;
        host_addr  = v.addr;
        host_wdata = v.wd;
    endtask

    logic done = 1'b0;

    initial begin
        vec_t idle_v;
        idle_v = VECS[NV-1];

        // R13 reset state, with a live word read on the inputs
        apply(VECS[0]);
        repeat (3) @(negedge clk);
        check_all("R13 reset", idle_v);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            apply(VECS[i]);
            @(negedge clk);
            check_all($sformatf("vector %0d", i), VECS[i]);
            if (VECS[i].wr && !VECS[i].io && !VECS[i].rd)
                check("R6 mem_wdata", 32'(mem_wdata), 32'(VECS[i].wd));
        end

        // R5 bank address = host bits 19..1
        @(negedge clk);
        apply(idle_v);
        host_addr = 20'hABCDF;
        @(negedge clk);
        check("R5 bank_addr", 32'(bank_addr), 32'h55E6F);
        host_addr = 20'hFFFFE;
        @(negedge clk);
        check("R5 bank_addr top", 32'(bank_addr), 32'h7FFFF);

        // R13 one-cycle latency: new cycle not visible before the edge
        apply(idle_v);
        @(negedge clk);
        apply(VECS[0]);
        #1;
        check_all("R13 before edge", idle_v);
        @(negedge clk);
        check_all("R13 after edge", VECS[0]);

        // R7 read data follows bank bytes combinationally within a cycle
        even_rdata = 8'h11;
        odd_rdata  = 8'hEE;
        #1;
        check("R7 live lanes", 32'(host_rdata), 32'h0000EE11);

        // R11 ignored I/O write leaves per_wdata zero after a copy
        @(negedge clk);
        apply(VECS[8]);
        @(negedge clk);
        apply(VECS[15]);
        @(negedge clk);
        check("R11 per_wdata", 32'(per_wdata), 32'h0);
        check("R11 per_wr", 32'(per_wr), 32'h0);

        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                n_chk++;
                n_bad++;
                $display("FAIL watchdog actual=hung expected=done");
            end
        join_any
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule